// File: doc/BRIEF.md
# Partitionable Packed-Lane Integer Adder

This block adds or subtracts two 36-bit packed operands. On every operation the datapath can be split into one 36-bit lane, two 18-bit lanes or four 9-bit lanes. Each lane is computed on its own in the same cycle. The carry chain is cut at every active lane boundary, so a carry or borrow from one lane never reaches the next. The split is chosen per operation, which lets a stream of operations change lane width from one cycle to the next.

Each lane either wraps modulo its width or clamps to its limits. The limits are either the signed range or the unsigned range, picked by a signed/unsigned select. Each active lane reports one overflow flag. The packed result and the flags are registered, and a valid strobe marks them one clock after the operation is presented.

Top module: `simd_lane_adder`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `result` and `ovf` are all zero until the first accepted operation.
- R2: `lane_mode` 2'b00 gives one 36-bit lane, 2'b01 gives two 18-bit lanes (bits 17:0 and 35:18), and 2'b10 gives four 9-bit lanes (bits 8:0, 17:9, 26:18, 35:27). The code 2'b11 behaves exactly as 2'b00. No carry crosses an active lane boundary.
- R3: When `sub_en` is 1, each lane computes a minus b modulo 2^width. When it is 0, each lane computes a plus b modulo 2^width, provided no clamping applies.
- R4: When `sat_signed` is 0, a lane's overflow condition is a carry out of the lane on addition, or a borrow (a < b, unsigned) on subtraction.
- R5: When `sat_signed` is 1, a lane's overflow condition is a two's-complement result outside the lane's signed range.
- R6: When `sat_en` is 1 and `sat_signed` is 0, an overflowing lane reads all ones on addition and zero on subtraction.
- R7: When `sat_en` is 1 and `sat_signed` is 1, an overflowing lane reads the most positive lane value if operand a's lane is non-negative, and the most negative lane value otherwise.
- R8: A lane's overflow flag is at `ovf` bit (lowest 9-bit segment index of that lane): bit 0 in 1x36; bits 0 and 2 in 2x18; bits 0..3 in 4x9. All other `ovf` bits read zero. Flags are reported whether or not `sat_en` is set.
- R9: `out_valid` equals `in_valid` delayed by one clock. The result and flags of an operation appear in the cycle after it is presented.
- R10: A cycle with `in_valid` low leaves `result` and `ovf` unchanged. Back-to-back operations may each use a different mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 36 | Packed operand a |
| op_b | input | 36 | Packed operand b |
| lane_mode | input | 2 | Lane split: 00 1x36, 01 2x18, 10 4x9, 11 as 00 |
| sub_en | input | 1 | 1 = a minus b, 0 = a plus b |
| sat_en | input | 1 | Clamp overflowing lanes instead of wrapping |
| sat_signed | input | 1 | 1 = signed range and flag, 0 = unsigned |
| out_valid | output | 1 | Result and flags valid |
| result | output | 36 | Packed registered result |
| ovf | output | 4 | Per-lane overflow flags at each lane's lowest segment bit |

## Verification
Several properties are checked on every cycle:
- the one-clock valid delay;
- holding of result and flags in idle cycles;
- zero upper flag bits in the single-lane modes;
- wrap of the lowest 9-bit lane without clamping;
- the clamp values of the lowest lane under both saturation kinds.

Only the bench scenarios show the remaining behaviour. These are full lane-by-lane arithmetic against an independent model in every mode, and carry isolation in the upper lanes. They also cover the reserved mode code, flag placement in 2x18, and mode changes between consecutive operations.

// File: rtl/simd_add_pkg.sv
`timescale 1ns/1ps
package simd_add_pkg;

   typedef enum logic [1:0] {
      MODE_WHOLE   = 2'b00,
      MODE_HALF    = 2'b01,
      MODE_QUARTER = 2'b10,
      MODE_RSVD    = 2'b11
   } lane_mode_e;

endpackage

// File: rtl/simd_lane_map.sv
`timescale 1ns/1ps
// Marks which segments open and close a lane for the chosen split.
module simd_lane_map
   import simd_add_pkg::*;
#(
   parameter int SEGS = 4
) (
   input  lane_mode_e        mode,
   output logic [SEGS-1:0]   lane_start,
   output logic [SEGS-1:0]   lane_end
);
   localparam int MID = SEGS / 2;

   always_comb begin
      for (int i = 0; i < SEGS; i++) begin
         lane_start[i] = (i == 0) || (mode == MODE_QUARTER) ||
                         ((mode == MODE_HALF) && (i == MID));
         lane_end[i]   = (i == SEGS - 1) || (mode == MODE_QUARTER) ||
                         ((mode == MODE_HALF) && (i == MID - 1));
      end
   end
endmodule

// File: rtl/simd_seg_add.sv
`timescale 1ns/1ps
// One segment of the split carry chain; exposes the carry into its MSB.
module simd_seg_add #(
   parameter int W = 9
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         c_msb
);
   logic [W-1:0] bx;
   logic [W-1:0] low;
   logic [1:0]   hi;

   assign bx    = sub ? ~b : b;
   assign low   = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, cin};
   assign c_msb = low[W-1];
   assign hi    = {1'b0, a[W-1]} + {1'b0, bx[W-1]} + {1'b0, c_msb};
   assign sum   = {hi[0], low[W-2:0]};
   assign cout  = hi[1];
endmodule

// File: rtl/simd_seg_sat.sv
`timescale 1ns/1ps
// Picks wrap or clamp value for one segment of a lane.
module simd_seg_sat #(
   parameter int W = 9
) (
   input  logic [W-1:0] sum,
   input  logic         lane_ovf,
   input  logic         sat_en,
   input  logic         sat_signed,
   input  logic         sub,
   input  logic         a_sign,
   input  logic         is_top,
   output logic [W-1:0] res
);
   logic [W-1:0] clamp;

   always_comb begin
      if (!sat_signed)
         clamp = {W{~sub}};
      else if (is_top)
         clamp = {a_sign, {(W-1){~a_sign}}};
      else
         clamp = {W{~a_sign}};
      res = (sat_en && lane_ovf) ? clamp : sum;
   end
endmodule

// File: rtl/simd_lane_adder.sv
`timescale 1ns/1ps
module simd_lane_adder
   import simd_add_pkg::*;
#(
   parameter  int SEG_W  = 9,
   parameter  int SEGS   = 4,
   localparam int DATA_W = SEG_W * SEGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [1:0]        lane_mode,
   input  logic              sub_en,
   input  logic              sat_en,
   input  logic              sat_signed,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [SEGS-1:0]   ovf
);
   generate
      if (SEG_W < 2) begin : g_bad_w
         $error("SEG_W must be at least 2");
      end
      if ((SEGS < 2) || (SEGS % 2 != 0)) begin : g_bad_segs
         $error("SEGS must be even and at least 2");
      end
   endgenerate

   lane_mode_e           mode;
   logic [SEGS-1:0]      lane_start, lane_end;
   logic [SEGS-1:0]      cin, cout, cmsb, seg_ovf, lane_ovf, lane_sign;
   logic [DATA_W-1:0]    next_res;
   logic [SEGS-1:0]      next_flag;

   assign mode = lane_mode_e'(lane_mode);

   simd_lane_map #(.SEGS(SEGS)) u_map (
      .mode       (mode),
      .lane_start (lane_start),
      .lane_end   (lane_end)
   );

   genvar g;
   generate
      for (g = 0; g < SEGS; g++) begin : g_seg
         logic [SEG_W-1:0] sum;

         if (g == 0) begin : g_c0
            assign cin[g] = sub_en;
         end else begin : g_cn
            assign cin[g] = lane_start[g] ? sub_en : cout[g-1];
         end

         simd_seg_add #(.W(SEG_W)) u_add (
            .a     (op_a[g*SEG_W +: SEG_W]),
            .b     (op_b[g*SEG_W +: SEG_W]),
            .sub   (sub_en),
            .cin   (cin[g]),
            .sum   (sum),
            .cout  (cout[g]),
            .c_msb (cmsb[g])
         );

         assign seg_ovf[g] = sat_signed ? (cmsb[g] ^ cout[g])
                                        : (sub_en ? ~cout[g] : cout[g]);

         if (g == SEGS - 1) begin : g_top
            assign lane_ovf[g]  = seg_ovf[g];
            assign lane_sign[g] = op_a[DATA_W-1];
         end else begin : g_mid
            assign lane_ovf[g]  = lane_end[g] ? seg_ovf[g] : lane_ovf[g+1];
            assign lane_sign[g] = lane_end[g] ? op_a[g*SEG_W + SEG_W - 1]
                                              : lane_sign[g+1];
         end

         simd_seg_sat #(.W(SEG_W)) u_sat (
            .sum        (sum),
            .lane_ovf   (lane_ovf[g]),
            .sat_en     (sat_en),
            .sat_signed (sat_signed),
            .sub        (sub_en),
            .a_sign     (lane_sign[g]),
            .is_top     (lane_end[g]),
            .res        (next_res[g*SEG_W +: SEG_W])
         );

         assign next_flag[g] = lane_start[g] & lane_ovf[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         ovf       <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= next_res;
            ovf    <= next_flag;
         end
      end
   end

   // R9: strobe tracks the accepted operation by one clock
   p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10: idle cycles keep outputs
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(ovf)));

   // R8: single-lane modes leave upper flag bits clear
   p_unused_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((mode == MODE_WHOLE) || (mode == MODE_RSVD)))
      |=> (ovf[SEGS-1:1] == '0));

   // R2: lowest narrow lane wraps on its own without clamping
   p_lane_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sat_en && !sub_en && (mode == MODE_QUARTER))
      |=> (result[SEG_W-1:0] ==
           SEG_W'($past(op_a[SEG_W-1:0]) + $past(op_b[SEG_W-1:0]))));

   // R7: signed clamp of lowest narrow lane is one of the two range limits
   p_sat_signed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && sat_signed && (mode == MODE_QUARTER))
      |=> (!ovf[0] ||
           (result[SEG_W-1:0] == {1'b0, {(SEG_W-1){1'b1}}}) ||
           (result[SEG_W-1:0] == {1'b1, {(SEG_W-1){1'b0}}})));

   // R6: unsigned clamped subtract floors at zero
   p_unsat_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && !sat_signed && sub_en)
      |=> (!ovf[0] || (result[SEG_W-1:0] == '0)));
endmodule

// File: tb/sim_simd_lane_adder.sv
`timescale 1ns/1ps
module sim_simd_lane_adder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [35:0] op_a = '0, op_b = '0;
   logic [1:0]  lane_mode = 2'b00;
   logic        sub_en = 1'b0, sat_en = 1'b0, sat_signed = 1'b0;
   logic        out_valid;
   logic [35:0] result;
   logic [3:0]  ovf;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   simd_lane_adder u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .lane_mode(lane_mode),
      .sub_en(sub_en), .sat_en(sat_en), .sat_signed(sat_signed),
      .out_valid(out_valid), .result(result), .ovf(ovf)
   );

   // {mode, sub, sat, signed, a, b}
   localparam int NV = 16;
   localparam logic [76:0] VEC [NV] = '{
      {2'b10, 1'b0, 1'b0, 1'b0, 36'h1FF_00FF1, 36'h0_01_00_00F},
      {2'b01, 1'b0, 1'b0, 1'b0, 36'h3FFFF_FFFF, 36'h00001_0001},
      {2'b00, 1'b0, 1'b0, 1'b0, 36'h7_FFFF_FFFF, 36'h0_0000_0001},
      {2'b10, 1'b1, 1'b0, 1'b0, 36'h0_0000_0000, 36'h0_0402_0101},
      {2'b01, 1'b1, 1'b1, 1'b0, 36'h0_0001_0005, 36'h0_0002_0009},
      {2'b10, 1'b0, 1'b1, 1'b1, 36'h3_FC7F_8FF0, 36'h0_0402_0101},
      {2'b00, 1'b0, 1'b1, 1'b1, 36'h7_FFFF_FFF0, 36'h0_0000_0100},
      {2'b00, 1'b1, 1'b1, 1'b1, 36'h8_0000_0004, 36'h0_0000_0010},
      {2'b11, 1'b0, 1'b0, 1'b0, 36'hF_FFFF_FFFF, 36'h0_0000_0002},
      {2'b01, 1'b0, 1'b1, 1'b1, 36'h9_0003_8000, 36'h9_0003_8000},
      {2'b10, 1'b1, 1'b1, 1'b1, 36'h8_0402_0101, 36'h3_FC7F_8FF0},
      {2'b10, 1'b0, 1'b1, 1'b0, 36'hA_BCDE_F123, 36'h9_8765_4321},
      {2'b01, 1'b1, 1'b0, 1'b1, 36'h1_2345_6789, 36'h8_7654_3210},
      {2'b00, 1'b1, 1'b0, 1'b0, 36'h1_0000_0000, 36'h2_0000_0000},
      {2'b11, 1'b1, 1'b1, 1'b1, 36'h0_0000_0001, 36'h7_FFFF_FFFF},
      {2'b10, 1'b0, 1'b0, 1'b1, 36'h5_5555_5555, 36'hA_AAAA_AAAA}
   };

   // Independent lane-by-lane model of the requirements
   task automatic ref_op(input logic [1:0] md, input logic sb, st, sg,
                         input logic [35:0] a, input logic [35:0] b,
                         output logic [35:0] r, output logic [3:0] f);
      int n;
      n = (md == 2'b01) ? 2 : (md == 2'b10) ? 4 : 1;
      r = '0;
      f = '0;
      for (int k = 0; k < n; k++) begin
         int w;
         longint mask, al, bl, us, sa, sbv, ss, smax, smin, v;
         logic fl;
         w    = 36 / n;
         mask = (longint'(1) << w) - 1;
         al   = (longint'(a) >> (k * w)) & mask;
         bl   = (longint'(b) >> (k * w)) & mask;
         smax = (longint'(1) << (w - 1)) - 1;
         smin = -(longint'(1) << (w - 1));
         sa   = (al > smax) ? al - (mask + 1) : al;
         sbv  = (bl > smax) ? bl - (mask + 1) : bl;
         us   = sb ? al - bl : al + bl;
         ss   = sb ? sa - sbv : sa + sbv;
         fl   = sg ? ((ss > smax) || (ss < smin)) : (sb ? (al < bl) : (us > mask));
         v    = us;
         if (st && fl) begin
            if (!sg) v = sb ? 0 : mask;
            else     v = (sa >= 0) ? smax : smin;
         end
         r = r | 36'((v & mask) << (k * w));
         f[k * (4 / n)] = fl;
      end
   endtask

   task automatic check(input string req, input string what,
                        input logic [40:0] got, input logic [40:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // Present one operation at a negedge, sample at the following negedge.
   task automatic run_op(input logic [1:0] md, input logic sb, st, sg,
                         input logic [35:0] a, input logic [35:0] b,
                         input string req);
      logic [35:0] er;
      logic [3:0]  ef;
      ref_op(md, sb, st, sg, a, b, er, ef);
      lane_mode = md; sub_en = sb; sat_en = st; sat_signed = sg;
      op_a = a; op_b = b; in_valid = 1'b1;
      @(negedge clk);
      check(req, "valid/result/flags", {out_valid, result, ovf}, {1'b1, er, ef});
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [40:0] snap;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1", "reset state", {out_valid, result, ovf}, 41'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "after release", {out_valid, result, ovf}, 41'd0);

      // Table walk: back-to-back operations with changing modes (R2..R10)
      for (int i = 0; i < NV; i++) begin
         logic [76:0] v;
         v = VEC[i];
         run_op(v[76:75], v[74], v[73], v[72], v[71:36], v[35:0], "R2/R3/R4/R5/R10");
      end

      // R9: strobe drops one cycle after in_valid drops
      in_valid = 1'b0;
      snap = {1'b0, result, ovf};
      op_a = 36'h1_2345_6789; op_b = 36'hF_FFFF_FFFF; lane_mode = 2'b10;
      @(negedge clk);
      check("R9", "strobe low after idle", {40'd0, out_valid}, 41'd0);
      // R10: idle cycle leaves outputs unchanged
      check("R10", "hold on idle", {1'b0, result, ovf}, snap);

      // R2: carry isolated in 4x9, all lanes wrap (unsigned flags)
      run_op(2'b10, 1'b0, 1'b0, 1'b0, {4{9'h1FF}}, {4{9'h001}}, "R2");
      check("R2", "4x9 wrap", {1'b0, result, ovf}, {1'b0, 36'd0, 4'b1111});
      // R2: same operands as one lane carry through
      run_op(2'b00, 1'b0, 1'b0, 1'b0, {4{9'h1FF}}, 36'd1, "R2");
      check("R2", "1x36 carry", {1'b0, result, ovf}, {1'b0, 36'd0, 4'b0001});
      // R2: reserved code acts as 1x36
      run_op(2'b11, 1'b0, 1'b0, 1'b0, 36'h0_0000_01FF, 36'd1, "R2");
      check("R2", "reserved mode", {1'b0, result, ovf}, {1'b0, 36'h200, 4'b0000});
      // R7/R8: signed clamp in 2x18, flags at bits 0 and 2
      run_op(2'b01, 1'b0, 1'b1, 1'b1, {2{18'h1FFFF}}, {2{18'h00001}}, "R7");
      check("R8", "2x18 flag position", {1'b0, result, ovf},
            {1'b0, {2{18'h1FFFF}}, 4'b0101});
      // R6: unsigned clamped subtract floors each 9-bit lane at zero
      run_op(2'b10, 1'b1, 1'b1, 1'b0, 36'd0, {4{9'h001}}, "R6");
      check("R6", "unsigned floor", {1'b0, result, ovf}, {1'b0, 36'd0, 4'b1111});
      // R6: unsigned clamped add ceilings at all ones
      run_op(2'b01, 1'b0, 1'b1, 1'b0, {2{18'h3FFF0}}, {2{18'h00020}}, "R6");
      check("R6", "unsigned ceiling", {1'b0, result, ovf},
            {1'b0, {2{18'h3FFFF}}, 4'b0101});
      // R7: signed clamp to most negative in 1x36
      run_op(2'b00, 1'b1, 1'b1, 1'b1, 36'h8_0000_0000, 36'd1, "R7");
      check("R7", "signed floor", {1'b0, result, ovf}, {1'b0, 36'h8_0000_0000, 4'b0001});
      // R4/R5: flag follows sat_signed even without clamping
      run_op(2'b10, 1'b0, 1'b0, 1'b1, {4{9'h0FF}}, {4{9'h001}}, "R5");
      check("R5", "signed flag", {1'b0, result, ovf}, {1'b0, {4{9'h100}}, 4'b1111});
      run_op(2'b10, 1'b0, 1'b0, 1'b0, {4{9'h0FF}}, {4{9'h001}}, "R4");
      check("R4", "no unsigned flag", {1'b0, result, ovf}, {1'b0, {4{9'h100}}, 4'b0000});
      // R3: wrapping subtract per lane
      run_op(2'b01, 1'b1, 1'b0, 1'b0, {18'h00005, 18'h00003}, {18'h00002, 18'h00004}, "R3");
      check("R3", "2x18 subtract", {1'b0, result, ovf},
            {1'b0, 18'h00003, 18'h3FFFF, 4'b0001});

      in_valid = 1'b0;
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule